// File: doc/BRIEF.md
# Address Bus Grant Qualifier with Retry Handling

This block sits on the master side of a shared, pipelined address bus. It decides when the local master may actually take ownership of the bus. The address-bus grant alone is not enough. The master must also see the shared address-retry line negated during the retry window, which is the single cycle after an address acknowledge. If retry is seen asserted in that window, every grant in that cycle and in the following cycle is refused. The block keeps the bus request up while work is outstanding. It emits a one-cycle take-ownership strobe and says whether that tenure is for an ordinary transfer or for a modified-block push.

When the local snoop logic reports a hit on a modified block during another master's address tenure, the block does three things. It drives the address-retry line in the window cycle. It raises its own bus request in the very next cycle. It then takes the bus for the push as soon as a qualified grant arrives, and that push goes ahead of any ordinary transfer that is waiting. If one of the master's own tenures is retried, the request is raised again and the same transfer is tried later.

Top module: `busq_top`

## Requirements
- R1: `takeOwn` is high only when `busReq` is high, `busGrant` is high, grants are not blocked (R3), and no tenure of this master is in progress (R8).
- R2: The retry window is the cycle that directly follows a cycle with `addrAck` high. Retry (`retryIn` or the block's own `retryDrive`) seen in any other cycle has no effect on grants.
- R3: When retry is seen high in a window cycle, grants are ignored in that cycle and for BLOCK_LEN-1 further cycles. The default BLOCK_LEN is 2, so the default blocks the retry cycle and the one after it.
- R4: If `snoopHitMod` is high in a cycle with `addrAck` high and this master is not in its own address phase, `retryDrive` is high in the next cycle (the window) and only in that cycle.
- R5: In the cycle after `retryDrive` is high, `busReq` is high, because a block-push request is now pending.
- R6: A pending push is served before a pending ordinary transfer. `takePush` is high together with `takeOwn` exactly when the accepted tenure is a push.
- R7: `busReq` is high in every cycle in which an ordinary transfer or a push is pending and not yet accepted. A request stops being pending in the cycle after its `takeOwn`.
- R8: `takeOwn` lasts one cycle. After a take, the master owns the address phase until `addrAck`, then waits through the window cycle. No further take happens in that span, however long `busGrant` stays high.
- R9: If retry is seen in the window of this master's own tenure, the same kind of request (ordinary or push) becomes pending again from the next cycle.
- R10: `newXfer` is ignored while an ordinary transfer is pending or in tenure. `snoopHitMod` is ignored while this master is in its own address phase.
- R11: While `rstN` is low, `busReq`, `takeOwn`, `takePush` and `retryDrive` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| newXfer | input | 1 | One-cycle pulse: the core has a new ordinary address transfer |
| busGrant | input | 1 | Address bus grant from the arbiter |
| addrAck | input | 1 | Address acknowledge; ends the current address tenure |
| retryIn | input | 1 | Shared address-retry line as driven by other agents |
| snoopHitMod | input | 1 | Local snoop hit on a modified block, valid with `addrAck` |
| busReq | output | 1 | Address bus request to the arbiter |
| takeOwn | output | 1 | One-cycle strobe: a qualified grant was accepted |
| takePush | output | 1 | With `takeOwn`: the accepted tenure is a modified-block push |
| retryDrive | output | 1 | Drive of the address-retry line after a local modified hit |

## Verification
The bench builds the block with BLOCK_LEN at its default of 2, which is the spacing the bus rules require. That setting puts the two-cycle grant blackout and the push request in the cycle after a retry in reach. It also puts their overlap in reach: a grant offered in the cycle where the push request first rises must still be refused. Directed scenarios cover several cases. One is a grant held through a whole tenure. Others are a retry outside the window, retries of both an ordinary tenure and a push tenure, and a push that overtakes a waiting ordinary transfer. A long pseudo-random phase then mixes acknowledges, retries and snoop hits so that pipelined acknowledges from other masters line up against the local tenure.

// File: rtl/busq_pkg.sv
package busq_pkg;

  // Strobes from the control section into the datapath.
  typedef struct packed {
    logic takeOrd;    // ordinary request accepted this cycle
    logic takePush;   // push request accepted this cycle
    logic againOrd;   // own ordinary tenure retried, re-arm it
    logic againPush;  // own push tenure retried, re-arm it
  } ctlStrb_t;

  typedef enum logic [1:0] {
    TEN_IDLE = 2'd0,
    TEN_ADDR = 2'd1,
    TEN_WIN  = 2'd2
  } tenSt_t;

endpackage

// File: rtl/busq_dp.sv
module busq_dp
  import busq_pkg::*;
#(
  parameter int BLOCK_LEN = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     newXfer,
  input  logic     addrAck,
  input  logic     retryIn,
  input  logic     snoopHitMod,
  input  logic     ownAddr,
  input  logic     ordBusy,
  input  ctlStrb_t strb,
  output logic     busReq,
  output logic     xferPend,
  output logic     pushPend,
  output logic     retrySeen,
  output logic     blocked,
  output logic     retryDrive
);

  localparam int CW = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) + 1 : 1;
  localparam logic [CW-1:0] BLK_RELOAD = CW'(BLOCK_LEN - 1);

  logic          ackQ;
  logic [CW-1:0] blockCnt;

  // Window cycle is the one right after an acknowledge; retry counts only there.
  assign retrySeen = ackQ & (retryIn | retryDrive);
  assign blocked   = retrySeen | (blockCnt != '0);
  assign busReq    = xferPend | pushPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ       <= 1'b0;
      retryDrive <= 1'b0;
      blockCnt   <= '0;
      pushPend   <= 1'b0;
      xferPend   <= 1'b0;
    end else begin
      ackQ       <= addrAck;
      retryDrive <= addrAck & snoopHitMod & ~ownAddr;
      if (retrySeen)
        blockCnt <= BLK_RELOAD;
      else if (blockCnt != '0)
        blockCnt <= blockCnt - 1'b1;
      pushPend <= (pushPend & ~strb.takePush) | retryDrive | strb.againPush;
      xferPend <= (xferPend & ~strb.takeOrd) | (newXfer & ~xferPend & ~ordBusy)
                  | strb.againOrd;
    end
  end

  // R4: local retry appears only in a window cycle
  p_drive_in_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    retryDrive |-> $past(addrAck));

  // R5: the push request follows a local retry on the next cycle
  p_push_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    retryDrive |=> busReq);

  // R4: the drive lasts a single cycle unless a fresh hit follows
  p_drive_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (retryDrive && !($past(addrAck) && addrAck && snoopHitMod && !ownAddr)) |=> !retryDrive);

endmodule

// File: rtl/busq_ctl.sv
module busq_ctl
  import busq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     busGrant,
  input  logic     addrAck,
  input  logic     xferPend,
  input  logic     pushPend,
  input  logic     retrySeen,
  input  logic     blocked,
  output ctlStrb_t strb,
  output logic     takeOwn,
  output logic     takePush,
  output logic     ownAddr,
  output logic     ordBusy
);

  tenSt_t tenSt, tenNx;
  logic   tenPush;

  always_comb begin
    takeOwn  = (tenSt == TEN_IDLE) & (xferPend | pushPend) & busGrant & ~blocked;
    takePush = takeOwn & pushPend;   // push wins over ordinary
    strb.takePush  = takePush;
    strb.takeOrd   = takeOwn & ~pushPend;
    strb.againOrd  = (tenSt == TEN_WIN) & retrySeen & ~tenPush;
    strb.againPush = (tenSt == TEN_WIN) & retrySeen & tenPush;
    ownAddr = (tenSt == TEN_ADDR);
    ordBusy = (tenSt != TEN_IDLE) & ~tenPush;
  end

  always_comb begin
    tenNx = tenSt;
    case (tenSt)
      TEN_IDLE: if (takeOwn) tenNx = TEN_ADDR;
      TEN_ADDR: if (addrAck) tenNx = TEN_WIN;
      TEN_WIN:  tenNx = TEN_IDLE;
      default:  tenNx = TEN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tenSt   <= TEN_IDLE;
      tenPush <= 1'b0;
    end else begin
      tenSt <= tenNx;
      if (takeOwn) tenPush <= pushPend;
    end
  end

  // R8: the take strobe never lasts two cycles
  p_take_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeOwn |=> !takeOwn);

  // R1: a take needs grant, request and no blackout
  p_take_qualified_r1: assert property (@(posedge clk) disable iff (!rstN)
    takeOwn |-> (busGrant && (xferPend || pushPend) && !blocked));

  // R6: a push flag never appears without a take
  p_push_with_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    takePush |-> takeOwn);

endmodule

// File: rtl/busq_top.sv
module busq_top #(
  parameter int BLOCK_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic newXfer,
  input  logic busGrant,
  input  logic addrAck,
  input  logic retryIn,
  input  logic snoopHitMod,
  output logic busReq,
  output logic takeOwn,
  output logic takePush,
  output logic retryDrive
);

  busq_pkg::ctlStrb_t strb;
  logic xferPend, pushPend, retrySeen, blocked, ownAddr, ordBusy;

  busq_dp #(.BLOCK_LEN(BLOCK_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .newXfer(newXfer), .addrAck(addrAck),
    .retryIn(retryIn), .snoopHitMod(snoopHitMod), .ownAddr(ownAddr),
    .ordBusy(ordBusy), .strb(strb), .busReq(busReq), .xferPend(xferPend),
    .pushPend(pushPend), .retrySeen(retrySeen), .blocked(blocked),
    .retryDrive(retryDrive)
  );

  busq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .addrAck(addrAck),
    .xferPend(xferPend), .pushPend(pushPend), .retrySeen(retrySeen),
    .blocked(blocked), .strb(strb), .takeOwn(takeOwn), .takePush(takePush),
    .ownAddr(ownAddr), .ordBusy(ordBusy)
  );

  // R3: no take in the retry cycle itself
  p_no_take_on_retry_r3: assert property (@(posedge clk) disable iff (!rstN)
    retrySeen |-> !takeOwn);

  generate
    if (BLOCK_LEN >= 2) begin : g_next_block
      // R3: nor in the cycle after it
      p_no_take_after_retry_r3: assert property (@(posedge clk) disable iff (!rstN)
        retrySeen |=> !takeOwn);
    end
  endgenerate

endmodule

// File: tb/tb_busq_top.sv
module tb_busq_top;

  localparam int BLK = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic newXfer = 1'b0, busGrant = 1'b0, addrAck = 1'b0, retryIn = 1'b0, snoopHitMod = 1'b0;
  logic busReq, takeOwn, takePush, retryDrive;

  always #5 clk = ~clk;

  busq_top #(.BLOCK_LEN(BLK)) dut (
    .clk(clk), .rstN(rstN), .newXfer(newXfer), .busGrant(busGrant),
    .addrAck(addrAck), .retryIn(retryIn), .snoopHitMod(snoopHitMod),
    .busReq(busReq), .takeOwn(takeOwn), .takePush(takePush), .retryDrive(retryDrive)
  );

  int vecs = 0;
  int bad  = 0;
  string tag = "R11";

  // Behavioural reference state (tenure: 0 idle, 1 address, 2 window)
  int mXfer = 0, mPush = 0, mTen = 0, mTenPush = 0, mAckQ = 0, mDrv = 0, mBlk = 0;

  task automatic cmp(input string what, input logic act, input int exp);
    if (act !== logic'(exp)) begin
      bad++;
      $display("FAIL %s %s: actual %0b expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic nx, input logic g, input logic a, input logic r, input logic s);
    int seen, blk, req, tk, tkP, nXfer, nPush, nTen, ordBusy;
    @(negedge clk);
    newXfer = nx; busGrant = g; addrAck = a; retryIn = r; snoopHitMod = s;
    #4;
    seen = (mAckQ != 0 && (r || mDrv != 0)) ? 1 : 0;
    blk  = (seen != 0 || mBlk > 0) ? 1 : 0;
    req  = (mXfer != 0 || mPush != 0) ? 1 : 0;
    tk   = (mTen == 0 && req != 0 && g && blk == 0) ? 1 : 0;
    tkP  = (tk != 0 && mPush != 0) ? 1 : 0;
    vecs++;
    begin
      int b0 = bad;
      cmp("busReq (R7)", busReq, req);
      cmp("takeOwn (R1)", takeOwn, tk);
      cmp("takePush (R6)", takePush, tkP);
      cmp("retryDrive (R4)", retryDrive, mDrv);
      if (bad > b0) bad = b0 + 1;
    end
    ordBusy = (mTen != 0 && mTenPush == 0) ? 1 : 0;
    nPush = (mPush != 0 && tkP == 0) || mDrv != 0 || (mTen == 2 && seen != 0 && mTenPush != 0);
    nXfer = (mXfer != 0 && !(tk != 0 && tkP == 0)) || (nx && mXfer == 0 && ordBusy == 0)
            || (mTen == 2 && seen != 0 && mTenPush == 0);
    if (mTen == 0) nTen = tk ? 1 : 0;
    else if (mTen == 1) nTen = a ? 2 : 1;
    else nTen = 0;
    if (tk) mTenPush = tkP;
    mBlk  = seen ? BLK - 1 : (mBlk > 0 ? mBlk - 1 : 0);
    mDrv  = (a && s && mTen != 1) ? 1 : 0;
    mAckQ = a ? 1 : 0;
    mPush = nPush; mXfer = nXfer; mTen = nTen;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    // R11: outputs low during reset, even with busy inputs
    repeat (3) begin
      @(negedge clk);
      newXfer = 1; busGrant = 1; addrAck = 1; snoopHitMod = 1;
      #4; vecs++;
      if ({busReq, takeOwn, takePush, retryDrive} !== 4'b0) begin
        bad++;
        $display("FAIL R11: actual %b expected 0000", {busReq, takeOwn, takePush, retryDrive});
      end
    end
    @(negedge clk);
    newXfer = 0; busGrant = 0; addrAck = 0; snoopHitMod = 0;
    rstN = 1;
    idle(2);

    // R7/R8: request held until grant; long grant gives one take
    tag = "R7";
    cyc(1, 0, 0, 0, 0); idle(3);
    tag = "R8";
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0); cyc(0, 1, 0, 0, 0); idle(2);

    // R2: retry outside window does not block
    tag = "R2";
    cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 0, 0, 0); idle(2);

    // R3: retry from another agent in window blocks two cycles
    tag = "R3";
    cyc(1, 0, 1, 0, 0); cyc(0, 1, 0, 1, 0); cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); idle(2);

    // R4/R5/R6: modified hit, push request, push before waiting ordinary
    tag = "R5";
    cyc(1, 0, 1, 0, 1); cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    tag = "R6";
    cyc(0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); idle(2);

    // R9: own ordinary tenure retried, then own push tenure retried
    tag = "R9";
    cyc(1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0); cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle(2);
    cyc(0, 0, 1, 0, 1); idle(2); cyc(0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0); idle(2); cyc(0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle(2);

    // R10: repeated newXfer and snoop hit during own address phase
    tag = "R10";
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1); cyc(0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle(3);

    // R1: pseudo-random mix against the reference model
    tag = "R1";
    for (int i = 0; i < 20000; i++)
      cyc(($urandom % 8) == 0, ($urandom % 3) != 0, ($urandom % 4) == 0,
          ($urandom % 5) == 0, ($urandom % 3) == 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule